// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block owns the command, bank, address and clock-enable pins of a DDR SDRAM from reset until the memory can accept normal traffic. After reset it keeps clock enable low for a settling time of at least 200 µs. The length of that wait in cycles comes from a clock-frequency parameter. It then raises clock enable with a NOP and issues a fixed DDR bring-up order: precharge all banks, write the extended mode register with the DLL on, and write the base mode register with the DLL-reset bit set. It then waits at least 200 cycles for the DLL to lock, precharges all banks again, issues two auto refreshes, and writes the base mode register once more with DLL reset cleared.

Every command is followed by NOP cycles. Their number comes from the parameterised precharge, mode-register and refresh recovery times. When the final recovery time has run out, a done flag rises and stays high, and a downstream controller takes over the bus. Pulling the asynchronous reset low at any time restarts the sequence from the settling wait.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset until the settling wait ends (CLK_MHZ*PWRUP_US cycles after reset release), cke_o is 0 and the bus is deselected (cs_n_o = 1, ras_n_o = cas_n_o = we_n_o = 1).
- R2: In the first cycle after the settling wait, cke_o rises and a NOP is driven ({cs_n,ras_n,cas_n,we_n} = 0111). cke_o then stays high until reset.
- R3: Two cycles after that NOP, a precharge-all is issued: pins 0010, addr_o bit 10 = 1, all other address bits 0, ba_o = 0.
- R4: A mode-register write to the extended register follows (pins 0000, ba_o = 01). Its address is EMR_VAL with bit 0 forced to 0, which enables the DLL.
- R5: A mode-register write to the base register follows (pins 0000, ba_o = 00). Its address is MR_VAL with bit 8 forced to 1, which resets the DLL.
- R6: No executable command is issued until at least max(DLL_LOCK, T_MRD) cycles after the DLL-reset command.
- R7: The first command after the DLL wait is a second precharge-all, encoded as in R3.
- R8: Exactly two auto refreshes follow (pins 0001, addr_o = 0, ba_o = 0), spaced T_RFC cycles apart.
- R9: The last command is a base mode-register write (ba_o = 00) with address MR_VAL and bit 8 forced to 0.
- R10: done_o rises exactly T_MRD cycles after the final mode-register write. From then on it stays high with cke_o high and NOP on the bus.
- R11: Each command is followed by NOPs up to the next command: max(T_RP,2) cycles after a precharge, max(T_MRD,2) after the extended write, max(T_RFC,2) after a refresh, and 2 after the first NOP.
- R12: Asserting rst_ni low at any point returns to the R1 state with done_o low. After release, the whole sequence repeats with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | A_W | Address bus |
| done_o | output | 1 | Initialization complete |

## Verification
The pins are decoded straight from the step register, so a wrong step shows up on the bus in the same cycle as a wrong command or a wrong bank or address value. A timer that is off by even one cycle moves every later command and the done edge. That is why the bench compares the exact cycle of each command with a table computed from the parameters, and checks that every cycle in between is a NOP. A step that is skipped or repeated changes the number of refreshes or mode-register writes and fails the table walk at the next entry. An error in the reset path shows up as cke_o high, or done_o high, during the settling wait.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_PWR,
    ST_NOP,
    ST_PRE1,
    ST_EMR,
    ST_MRS_DLL,
    ST_PRE2,
    ST_REF1,
    ST_REF2,
    ST_MRS_RUN,
    ST_DONE
  } step_e;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam int unsigned DLL_RST_POS = 8;
  localparam int unsigned AP_POS      = 10;
  localparam int unsigned DLL_DIS_POS = 0;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic pins_t cmd_pins(input cmd_e c);
    pins_t p;
    unique case (c)
      CMD_NOP: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      CMD_PRE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_REF: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      CMD_MRS: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default: p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

  function automatic step_e next_step(input step_e s);
    step_e n;
    unique case (s)
      ST_PWR:     n = ST_NOP;
      ST_NOP:     n = ST_PRE1;
      ST_PRE1:    n = ST_EMR;
      ST_EMR:     n = ST_MRS_DLL;
      ST_MRS_DLL: n = ST_PRE2;
      ST_PRE2:    n = ST_REF1;
      ST_REF1:    n = ST_REF2;
      ST_REF2:    n = ST_MRS_RUN;
      ST_MRS_RUN: n = ST_DONE;
      default:    n = ST_DONE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned INIT  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= CNT_W'(INIT);
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_step.sv
module ddr_init_step
  import ddr_init_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tmr_zero_i,
  output step_e step_o,
  output logic  in_gap_o,
  output logic  load_o
);

  step_e step_q, step_d;
  logic  gap_q, gap_d;

  always_comb begin
    step_d = step_q;
    gap_d  = gap_q;
    unique case (step_q)
      ST_PWR: begin
        if (tmr_zero_i) begin
          step_d = ST_NOP;
          gap_d  = 1'b0;
        end
      end
      ST_DONE: gap_d = 1'b0;
      default: begin
        if (!gap_q) begin
          gap_d = 1'b1;
        end else if (tmr_zero_i) begin
          step_d = next_step(step_q);
          gap_d  = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_PWR;
      gap_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      gap_q  <= gap_d;
    end
  end

  // timer is loaded in the single command cycle of each step
  assign load_o   = !gap_q && (step_q != ST_PWR) && (step_q != ST_DONE);
  assign step_o   = step_q;
  assign in_gap_o = gap_q;

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int unsigned A_W     = 13,
  parameter int unsigned BA_W    = 2,
  parameter logic [A_W-1:0] MR_VAL  = '0,
  parameter logic [A_W-1:0] EMR_VAL = '0
) (
  input  step_e            step_i,
  input  logic             in_gap_i,
  output pins_t            pins_o,
  output logic [BA_W-1:0]  ba_o,
  output logic [A_W-1:0]   addr_o,
  output logic             cke_o,
  output logic             done_o
);

  localparam logic [A_W-1:0] AP_MASK  = A_W'(1) << AP_POS;
  localparam logic [A_W-1:0] DLL_MASK = A_W'(1) << DLL_RST_POS;
  localparam logic [A_W-1:0] DIS_MASK = A_W'(1) << DLL_DIS_POS;
  localparam logic [A_W-1:0] EMR_ADDR = EMR_VAL & ~DIS_MASK;
  localparam logic [A_W-1:0] MR_RST   = MR_VAL | DLL_MASK;
  localparam logic [A_W-1:0] MR_RUN   = MR_VAL & ~DLL_MASK;
  localparam logic [BA_W-1:0] BA_BASE = '0;
  localparam logic [BA_W-1:0] BA_EXT  = BA_W'(1);

  cmd_e cmd;

  always_comb begin
    cmd    = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    if (step_i == ST_PWR) begin
      cmd = CMD_DESEL;
    end else if (!in_gap_i) begin
      unique case (step_i)
        ST_PRE1, ST_PRE2: begin
          cmd    = CMD_PRE;
          addr_o = AP_MASK;
        end
        ST_EMR: begin
          cmd    = CMD_MRS;
          ba_o   = BA_EXT;
          addr_o = EMR_ADDR;
        end
        ST_MRS_DLL: begin
          cmd    = CMD_MRS;
          ba_o   = BA_BASE;
          addr_o = MR_RST;
        end
        ST_MRS_RUN: begin
          cmd    = CMD_MRS;
          ba_o   = BA_BASE;
          addr_o = MR_RUN;
        end
        ST_REF1, ST_REF2: cmd = CMD_REF;
        default:          cmd = CMD_NOP;
      endcase
    end
  end

  assign pins_o = cmd_pins(cmd);
  assign cke_o  = (step_i != ST_PWR);
  assign done_o = (step_i == ST_DONE);

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 200,
  parameter int unsigned PWRUP_US = 200,
  parameter int unsigned DLL_LOCK = 200,
  parameter int unsigned T_RP     = 3,
  parameter int unsigned T_MRD    = 2,
  parameter int unsigned T_RFC    = 14,
  parameter int unsigned A_W      = 13,
  parameter int unsigned BA_W     = 2,
  parameter logic [A_W-1:0] MR_VAL  = 13'h0032,
  parameter logic [A_W-1:0] EMR_VAL = 13'h0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            cke_o,
  output logic            cs_n_o,
  output logic            ras_n_o,
  output logic            cas_n_o,
  output logic            we_n_o,
  output logic [BA_W-1:0] ba_o,
  output logic [A_W-1:0]  addr_o,
  output logic            done_o
);

  localparam int PWRUP_CYC = max2(int'(CLK_MHZ * PWRUP_US), 1);
  localparam int G_NOP     = 2;
  localparam int G_RP      = max2(int'(T_RP), 2);
  localparam int G_MRD     = max2(int'(T_MRD), 2);
  localparam int G_RFC     = max2(int'(T_RFC), 2);
  localparam int G_DLL     = max2(max2(int'(DLL_LOCK), int'(T_MRD)), 2);
  localparam int CNT_MAX   = max2(max2(PWRUP_CYC, G_DLL), max2(G_RP, G_RFC));
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  step_e            step;
  logic             in_gap, load, tmr_zero;
  logic [CNT_W-1:0] gap_val;
  pins_t            pins;

  ddr_init_timer #(
    .CNT_W(CNT_W),
    .INIT (PWRUP_CYC - 1)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .val_i (gap_val),
    .zero_o(tmr_zero)
  );

  ddr_init_step u_step (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tmr_zero_i(tmr_zero),
    .step_o    (step),
    .in_gap_o  (in_gap),
    .load_o    (load)
  );

  // command cycle + (gap-1) NOP cycles; timer counts gap-2 down to zero
  always_comb begin
    unique case (step)
      ST_NOP:              gap_val = CNT_W'(G_NOP - 2);
      ST_PRE1, ST_PRE2:    gap_val = CNT_W'(G_RP - 2);
      ST_EMR, ST_MRS_RUN:  gap_val = CNT_W'(G_MRD - 2);
      ST_MRS_DLL:          gap_val = CNT_W'(G_DLL - 2);
      ST_REF1, ST_REF2:    gap_val = CNT_W'(G_RFC - 2);
      default:             gap_val = '0;
    endcase
  end

  ddr_init_cmd_enc #(
    .A_W    (A_W),
    .BA_W   (BA_W),
    .MR_VAL (MR_VAL),
    .EMR_VAL(EMR_VAL)
  ) u_enc (
    .step_i  (step),
    .in_gap_i(in_gap),
    .pins_o  (pins),
    .ba_o    (ba_o),
    .addr_o  (addr_o),
    .cke_o   (cke_o),
    .done_o  (done_o)
  );

  assign cs_n_o  = pins.cs_n;
  assign ras_n_o = pins.ras_n;
  assign cas_n_o = pins.cas_n;
  assign we_n_o  = pins.we_n;

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int unsigned A_W      = 13,
  parameter int unsigned BA_W     = 2,
  parameter int unsigned DLL_LOCK = 200
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cke_o,
  input logic            cs_n_o,
  input logic            ras_n_o,
  input logic            cas_n_o,
  input logic            we_n_o,
  input logic [BA_W-1:0] ba_o,
  input logic [A_W-1:0]  addr_o,
  input logic            done_o
);

  localparam int unsigned LW = $clog2(DLL_LOCK + 1);

  logic [3:0] cmd;
  logic       is_nop, is_exec, is_mrs, is_pre, dll_rst;
  logic [LW-1:0] since_dll;

  assign cmd     = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  assign is_nop  = (cmd == 4'b0111);
  assign is_exec = !cs_n_o && !is_nop;
  assign is_mrs  = (cmd == 4'b0000);
  assign is_pre  = (cmd == 4'b0010);
  assign dll_rst = is_mrs && (ba_o == '0) && addr_o[8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       since_dll <= LW'(DLL_LOCK);
    else if (dll_rst)                  since_dll <= LW'(1);
    else if (since_dll < LW'(DLL_LOCK)) since_dll <= since_dll + 1'b1;
  end

  AST_PWR_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> cs_n_o);  // R1
  AST_CKE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);  // R2
  AST_PRE_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> addr_o[10]);  // R3
  AST_EMR_DLL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_mrs && ba_o == BA_W'(1)) |-> !addr_o[0]);  // R4
  AST_MRS_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |-> (ba_o[BA_W-1:1] == '0));  // R5
  AST_DLL_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_exec && !dll_rst) |-> (since_dll >= LW'(DLL_LOCK)));  // R6
  AST_CMD_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_exec |=> is_nop);  // R11
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);  // R10
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cke_o && is_nop));  // R10

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
  .A_W     (A_W),
  .BA_W    (BA_W),
  .DLL_LOCK(DLL_LOCK)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cke_o  (cke_o),
  .cs_n_o (cs_n_o),
  .ras_n_o(ras_n_o),
  .cas_n_o(cas_n_o),
  .we_n_o (we_n_o),
  .ba_o   (ba_o),
  .addr_o (addr_o),
  .done_o (done_o)
);

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PWR_CYC    = 400;  // CLK_MHZ=2, PWRUP_US=200
  localparam int N_ENT      = 8;
  localparam int DONE_CYC   = 628;

  // sequence table: cycle after reset release, pins {cs,ras,cas,we}, bank, address
  localparam int         EXP_CYC [N_ENT] = '{400, 402, 405, 407, 607, 610, 618, 626};
  localparam logic [3:0] EXP_PIN [N_ENT] = '{4'b0111, 4'b0010, 4'b0000, 4'b0000,
                                             4'b0010, 4'b0001, 4'b0001, 4'b0000};
  localparam logic [1:0] EXP_BA  [N_ENT] = '{2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
  localparam logic [12:0] EXP_ADR[N_ENT] = '{13'h000, 13'h400, 13'h002, 13'h162,
                                             13'h400, 13'h000, 13'h000, 13'h062};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, done_o;
  logic [1:0]  ba_o;
  logic [12:0] addr_o;

  int n_chk = 0;
  int n_fail = 0;
  int k;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ddr_init_seq #(
    .CLK_MHZ (2),
    .PWRUP_US(200),
    .DLL_LOCK(200),
    .T_RP    (3),
    .T_MRD   (2),
    .T_RFC   (8),
    .A_W     (13),
    .BA_W    (2),
    .MR_VAL  (13'h0162),
    .EMR_VAL (13'h0003)
  ) u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cke_o  (cke_o),
    .cs_n_o (cs_n_o),
    .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o),
    .we_n_o (we_n_o),
    .ba_o   (ba_o),
    .addr_o (addr_o),
    .done_o (done_o)
  );

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R7";
      5, 6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
    #1;
    k++;
  endtask

  task automatic release_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    k = 0;
  endtask

  task automatic walk_sequence(input string rq);
    bit ok;
    int bad_k;
    for (int i = 0; i < N_ENT; i++) begin
      ok = 1'b1;
      bad_k = -1;
      while (k < EXP_CYC[i]) begin
        if (i == 0) begin
          if (cke_o || !cs_n_o || !ras_n_o || !cas_n_o || !we_n_o || done_o) begin
            ok = 1'b0; if (bad_k < 0) bad_k = k;
          end
        end else if (!cke_o || done_o || {cs_n_o, ras_n_o, cas_n_o, we_n_o} != 4'b0111) begin
          ok = 1'b0; if (bad_k < 0) bad_k = k;
        end
        tick();
      end
      // R1 settling wait, R6 DLL lock gap, R11 recovery gaps
      check(ok, (i == 0) ? "R1" : (i == 4) ? "R6" : "R11",
            $sformatf("%s idle before entry %0d (first bad cycle)", rq, i), bad_k, EXP_CYC[i]);
      check({cke_o, done_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, ba_o, addr_o}
              == {1'b1, 1'b0, EXP_PIN[i], EXP_BA[i], EXP_ADR[i]},
            tag_of(i), $sformatf("%s command at cycle %0d", rq, k),
            {13'd0, cke_o, done_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, ba_o, addr_o},
            {13'd0, 1'b1, 1'b0, EXP_PIN[i], EXP_BA[i], EXP_ADR[i]});
      tick();
    end
    while (k < DONE_CYC - 1) tick();
    check(!done_o, "R10", "done early", {31'd0, done_o}, 32'd0);
    tick();
    check(done_o && cke_o, "R10", "done at final recovery", {30'd0, done_o, cke_o}, 32'd3);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    bit ok;
    k = 0;
    repeat (3) @(negedge clk_i);
    #1;
    check(!cke_o && cs_n_o && !done_o, "R1", "reset state",
          {29'd0, cke_o, cs_n_o, done_o}, 32'b010);

    release_reset();
    walk_sequence("run1");

    // R10: bus stays parked after done
    ok = 1'b1;
    for (int j = 0; j < 50; j++) begin
      tick();
      if (!done_o || !cke_o || {cs_n_o, ras_n_o, cas_n_o, we_n_o} != 4'b0111) ok = 1'b0;
    end
    check(ok, "R10", "hold after done", {31'd0, ok}, 32'd1);

    // R12: reset in the middle of the DLL wait
    @(negedge clk_i);
    rst_ni = 1'b0;
    release_reset();
    while (k < 500) tick();
    check(cke_o && !done_o, "R12", "mid-sequence before reset",
          {30'd0, cke_o, done_o}, 32'b10);
    rst_ni = 1'b0;
    #1;
    check(!cke_o && cs_n_o && !done_o, "R12", "async reset state",
          {29'd0, cke_o, cs_n_o, done_o}, 32'b010);
    repeat (2) @(negedge clk_i);
    release_reset();
    walk_sequence("R12 rerun");

    // R12: reset after done drops done immediately
    rst_ni = 1'b0;
    #1;
    check(!done_o && !cke_o, "R12", "reset after done",
          {30'd0, done_o, cke_o}, 32'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule